// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns the core clock into a stream of single-cycle ticks at sixteen times a serial baud rate, for the sampling logic of a UART receiver and transmitter. It reaches standard baud rates from a core clock that is not a round multiple of them. It does this with two stages. A binary prescaler divides the core clock by 2^E. A phase accumulator then adds a fixed step of 32 on every prescaled clock, against a modulus of F + 64. Here E is the programmed exponent and F is the programmed 8-bit fractional value.

The resulting baud rate is 2·Fcore / (2^E·(F + 64)). Software picks E as floor(log2(Fcore / (32·baud))). It picks F as 2·Fcore / (baud·2^E) − 64. Both values are loaded with a single write strobe. Each write restarts both stages, so the first tick period after a change is a full, clean one.

An enable input selects this generator as the bit clock of the serial port. While the enable is low, the generator stays cleared and issues nothing, and the serial port is left to its legacy timer.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the tick output is low and the stored configuration is exponent 0 and fraction 0. Enabling without any write therefore gives 10 ticks in the first 20 cycles.
- R2: While `gen_en` is low, `tick_16x` stays low.
- R3: `tick_16x` is never high in two consecutive cycles.
- R4: Counting cycles from the write cycle, after N further enabled cycles the number of ticks issued equals floor(32·floor(N / 2^E) / (F + 64)). E is the 3-bit `cfg_exp` and F is the 8-bit unsigned `cfg_frac`.
- R5: The first tick after a restart appears in cycle ceil((F + 64) / 32)·2^E after the restart.
- R6: A write (`cfg_wr` high for one cycle) loads `cfg_exp` and `cfg_frac`. It clears the prescaler, the accumulator and the tick in that cycle, even in the middle of a running stream.
- R7: All 8 exponents and all 256 fractional values are honoured, including the extremes E=0/F=0 (a tick every 2 cycles) and E=7/F=255.
- R8: Dropping `gen_en` clears the prescaler and accumulator. Raising it again restarts the tick stream exactly as a write of the stored configuration would.
- R9: Two ticks issued without an intervening restart are at least 2·2^E cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | Selects this generator as the serial bit clock; low holds it cleared |
| cfg_wr | input | 1 | One-cycle strobe that loads the exponent and fraction and restarts |
| cfg_exp | input | EXP_W (3) | Binary prescale exponent E |
| cfg_frac | input | FRAC_W (8) | Fractional divider value F |
| tick_16x | output | 1 | Single-cycle pulse at 16 times the baud rate |

## Verification
The hardest situation to reach is the phase of the accumulator after a restart lands at an arbitrary point of a running stream. An error there only shows as an off-by-one in tick count or first-tick position, many cycles later. The stimulus chains random configurations without gaps, so every write falls mid-stream at a random prescaler and accumulator phase. It also toggles the enable after runs of random length. After each restart, the exact tick count and first-tick cycle are compared with closed-form values, which exposes any phase left over from the previous run. Directed runs cover the fastest and slowest corners.

// File: rtl/frbg_pkg.sv
package frbg_pkg;

   // Prescaler implementation variants
   typedef enum logic {
      PRE_COMPARE = 1'b0,   // counter cleared on each prescaled pulse
      PRE_MASKED  = 1'b1    // free-running counter, pulse on all-ones low bits
   } pre_style_e;

   // Largest modulus the accumulator must hold
   function automatic int unsigned frbg_max_mod(input int unsigned frac_w,
                                                input int unsigned base);
      return ((32'd1 << frac_w) - 32'd1) + base;
   endfunction

   // Prescaler counter width for a given exponent field width
   function automatic int unsigned frbg_pre_width(input int unsigned exp_w);
      return (32'd1 << exp_w) - 32'd1;
   endfunction

endpackage

// File: rtl/frbg_cfg.sv
module frbg_cfg #(
   parameter int unsigned EXP_W  = 3,
   parameter int unsigned FRAC_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gen_en,
   input  logic              cfg_wr,
   input  logic [EXP_W-1:0]  cfg_exp,
   input  logic [FRAC_W-1:0] cfg_frac,
   output logic [EXP_W-1:0]  exp_q,
   output logic [FRAC_W-1:0] frac_q,
   output logic              restart
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_q  <= '0;
         frac_q <= '0;
      end else if (cfg_wr) begin
         exp_q  <= cfg_exp;
         frac_q <= cfg_frac;
      end
   end

   // Any write, or the generator being deselected, clears the datapath
   assign restart = cfg_wr | ~gen_en;

endmodule

// File: rtl/frbg_prescale.sv
module frbg_prescale
   import frbg_pkg::*;
#(
   parameter int unsigned EXP_W     = 3,
   parameter pre_style_e  PRE_STYLE = PRE_COMPARE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [EXP_W-1:0] exp_sel,
   output logic             pulse
);

   localparam int unsigned PRE_W = frbg_pre_width(EXP_W);

   logic [PRE_W-1:0] cnt_q;
   logic [PRE_W-1:0] mask;

   // Low exp_sel bits set: the terminal count of a divide by 2^exp_sel
   assign mask = ~({PRE_W{1'b1}} << exp_sel);

   generate
      if (PRE_STYLE == PRE_COMPARE) begin : g_compare
         assign pulse = (cnt_q == mask);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= '0;
            else if (clr)    cnt_q <= '0;
            else if (pulse)  cnt_q <= '0;
            else             cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_masked
         assign pulse = ((cnt_q & mask) == mask);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= '0;
            else if (clr)    cnt_q <= '0;
            else             cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/frbg_phase.sv
module frbg_phase
   import frbg_pkg::*;
#(
   parameter int unsigned FRAC_W    = 8,
   parameter int unsigned FRAC_BASE = 64,
   parameter int unsigned STEP      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              adv,
   input  logic [FRAC_W-1:0] frac,
   output logic              wrap
);

   localparam int unsigned MAX_MOD = frbg_max_mod(FRAC_W, FRAC_BASE);
   localparam int unsigned MOD_W   = $clog2(MAX_MOD + 1);
   localparam int unsigned SUM_W   = MOD_W + 1;

   logic [MOD_W-1:0] acc_q;
   logic [MOD_W-1:0] modv;
   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] rem;

   assign modv = MOD_W'(frac) + MOD_W'(FRAC_BASE);
   assign sum  = {1'b0, acc_q} + SUM_W'(STEP);
   assign rem  = sum - {1'b0, modv};
   assign wrap = adv && (sum >= {1'b0, modv});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q <= '0;
      else if (clr)    acc_q <= '0;
      else if (wrap)   acc_q <= rem[MOD_W-1:0];
      else if (adv)    acc_q <= sum[MOD_W-1:0];
   end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
   import frbg_pkg::*;
#(
   parameter int unsigned EXP_W     = 3,
   parameter int unsigned FRAC_W    = 8,
   parameter int unsigned FRAC_BASE = 64,
   parameter int unsigned OVS       = 16,
   parameter pre_style_e  PRE_STYLE = PRE_COMPARE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gen_en,
   input  logic              cfg_wr,
   input  logic [EXP_W-1:0]  cfg_exp,
   input  logic [FRAC_W-1:0] cfg_frac,
   output logic              tick_16x
);

   // Step per prescaled clock: the ratio holds 2 baud periods per (F+BASE)
   localparam int unsigned STEP = 2 * OVS;

   generate
      if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp
         $error("frac_baud_gen: EXP_W must lie in 1..5");
      end
      if (FRAC_W < 1) begin : g_bad_frac
         $error("frac_baud_gen: FRAC_W must be at least 1");
      end
      if (STEP > FRAC_BASE) begin : g_bad_step
         $error("frac_baud_gen: 2*OVS must not exceed FRAC_BASE");
      end
   endgenerate

   logic [EXP_W-1:0]  exp_q;
   logic [FRAC_W-1:0] frac_q;
   logic              restart;
   logic              pre_pulse;
   logic              wrap;
   logic              tick_q;

   frbg_cfg #(
      .EXP_W  (EXP_W),
      .FRAC_W (FRAC_W)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .gen_en   (gen_en),
      .cfg_wr   (cfg_wr),
      .cfg_exp  (cfg_exp),
      .cfg_frac (cfg_frac),
      .exp_q    (exp_q),
      .frac_q   (frac_q),
      .restart  (restart)
   );

   frbg_prescale #(
      .EXP_W     (EXP_W),
      .PRE_STYLE (PRE_STYLE)
   ) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (restart),
      .exp_sel (exp_q),
      .pulse   (pre_pulse)
   );

   frbg_phase #(
      .FRAC_W    (FRAC_W),
      .FRAC_BASE (FRAC_BASE),
      .STEP      (STEP)
   ) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (restart),
      .adv   (pre_pulse),
      .frac  (frac_q),
      .wrap  (wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tick_q <= 1'b0;
      else if (restart) tick_q <= 1'b0;
      else              tick_q <= wrap;
   end

   assign tick_16x = tick_q;

endmodule

// File: rtl/frbg_chk.sv
module frbg_chk #(
   parameter int unsigned EXP_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             gen_en,
   input logic             cfg_wr,
   input logic             tick_16x,
   input logic [EXP_W-1:0] exp_q
);

   localparam int unsigned GAP_W = 16;

   logic [GAP_W-1:0] gap_q;
   logic             seen_q;
   logic [GAP_W-1:0] min_gap;

   assign min_gap = GAP_W'(2) << exp_q;

   // Cycles since the last sampled tick, forgotten on every restart
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (cfg_wr || !gen_en) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (tick_16x) begin
         gap_q  <= GAP_W'(1);
         seen_q <= 1'b1;
      end else if (gap_q != {GAP_W{1'b1}}) begin
         gap_q  <= gap_q + 1'b1;
      end
   end

   a_r2_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_en |=> !tick_16x);

   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tick_16x |=> !tick_16x);

   a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> !tick_16x);

   a_r8_enable_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gen_en) |-> !tick_16x);

   a_r9_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_16x && seen_q) |-> (gap_q >= min_gap));

endmodule

bind frac_baud_gen frbg_chk #(.EXP_W(EXP_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .gen_en   (gen_en),
   .cfg_wr   (cfg_wr),
   .tick_16x (tick_16x),
   .exp_q    (exp_q)
);

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       gen_en = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [2:0] cfg_exp = '0;
   logic [7:0] cfg_frac = '0;
   logic       tick_16x;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   frac_baud_gen uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .gen_en   (gen_en),
      .cfg_wr   (cfg_wr),
      .cfg_exp  (cfg_exp),
      .cfg_frac (cfg_frac),
      .tick_16x (tick_16x)
   );

   function automatic int exp_count(int e, int f, int n);
      return (32 * (n >> e)) / (f + 64);
   endfunction

   function automatic int exp_first(int e, int f);
      return ((f + 64 + 31) / 32) << e;
   endfunction

   task automatic check(string req, int actual, int expected, string what);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
      end
   endtask

   // Runs n enabled cycles from the current negedge; counts ticks,
   // records the first tick cycle and any back-to-back ticks.
   task automatic observe(int n, output int cnt, output int first, output int dbl);
      bit prev = 0;
      cnt = 0; first = -1; dbl = 0;
      for (int i = 1; i <= n; i++) begin
         @(posedge clk); @(negedge clk);
         if (tick_16x) begin
            cnt++;
            if (first < 0) first = i;
            if (prev) dbl++;
         end
         prev = tick_16x;
      end
   endtask

   task automatic run_cfg(string req, int e, int f, int n);
      int cnt, first, dbl;
      cfg_exp = 3'(e); cfg_frac = 8'(f); cfg_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      cfg_wr = 1'b0;
      check(req, int'(tick_16x), 0, "tick right after write (R6)");
      observe(n - 1, cnt, first, dbl);
      // the write cycle itself is cycle 0; n-1 further cycles observed
      check(req, cnt, exp_count(e, f, n - 1), $sformatf("tick count R4 E=%0d F=%0d", e, f));
      if (exp_first(e, f) <= n - 1)
         check(req, first, exp_first(e, f), $sformatf("first tick R5 E=%0d F=%0d", e, f));
      check("R3", dbl, 0, "back-to-back ticks");
   endtask

   initial begin
      int cnt, first, dbl;
      void'($urandom(32'd20240607));
      repeat (3) @(negedge clk);
      check("R1", int'(tick_16x), 0, "tick during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", int'(tick_16x), 0, "tick after reset");

      // R1: default config E=0 F=0 after reset
      gen_en = 1'b1;
      observe(20, cnt, first, dbl);
      check("R1", cnt, 10, "ticks from reset configuration");

      // R7 extremes
      run_cfg("R7", 0, 0, 40);
      run_cfg("R7", 7, 255, 4000);
      run_cfg("R7", 0, 255, 700);
      run_cfg("R7", 7, 0, 600);

      // R6: write in the middle of a stream, then the same config again
      run_cfg("R6", 2, 100, 37);
      run_cfg("R6", 2, 100, 900);
      run_cfg("R6", 5, 13, 1500);

      // R2 and R8: disable, stay silent, re-enable restarts cleanly
      gen_en = 1'b0;
      observe(300, cnt, first, dbl);
      check("R2", cnt, 0, "ticks while disabled");
      gen_en = 1'b1;
      observe(1499, cnt, first, dbl);
      check("R8", cnt, exp_count(5, 13, 1499), "tick count after re-enable");
      check("R8", first, exp_first(5, 13), "first tick after re-enable");

      // R4/R5 random configurations chained back to back
      for (int k = 0; k < 14; k++) begin
         int e = int'($urandom % 8);
         int f = int'($urandom % 256);
         int n = exp_first(e, f) + 1 + int'($urandom % 2000);
         run_cfg("R4", e, f, n);
         if (k % 4 == 3) begin
            int off = 1 + int'($urandom % 200);
            gen_en = 1'b0;
            observe(off, cnt, first, dbl);
            check("R2", cnt, 0, "ticks while disabled (random)");
            gen_en = 1'b1;
            observe(n - 1, cnt, first, dbl);
            check("R8", cnt, exp_count(e, f, n - 1), "count after random re-enable");
         end
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule